// File: doc/BRIEF.md
# Fractional Tick Rate Bridge

This block sits behind a timer that has been reprogrammed to fire faster than the system expects. For each fast tick it adds a programmed increment to a running total. The increment is the number of base clock cycles between fast ticks, for example 11931 for a 1193181 Hz base and 100 ticks per second.

Whenever that total reaches the legacy period of 0x10000 base cycles, the block removes one period from the total and raises a legacy tick. That tick drives the slow consumer at its original rate of about 18.2 per second. When the total stays below the period, the block raises a local acknowledge instead. The remainder carries forward, so the long-term legacy rate stays exact and does not drift the way truncating division would.

Both outputs are registered. Each fast tick sampled on a clock edge yields exactly one one-clock pulse, visible after that same edge.

Top module: `frac_tick_bridge`

## Requirements
- R1: After reset both outputs are low and the running total is zero, so the first tick of increment 0x8000 gives an acknowledge.
- R2: Every clock edge with tick_i high adds the effective increment to the running total.
- R3: If the total after the add is at least 0x10000, the block subtracts 0x10000 and pulses legacy_tick_o in the cycle after the tick edge; a total equal to exactly 0x10000 counts as reaching the period.
- R4: If the total after the add is below 0x10000, the block pulses ack_o in the cycle after the tick edge and keeps the total.
- R5: Each sampled tick gives exactly one pulse, one clock wide, on exactly one of legacy_tick_o and ack_o. No pulse appears without a tick.
- R6: An increment of 0 acts as 0x10000: every such tick gives a legacy tick and leaves the running total unchanged.
- R7: Starting from a zero total, N ticks of a constant increment k (1..0xFFFF) produce floor(N*k/0x10000) legacy ticks.
- R8: The remainder after each subtraction carries into later ticks, so the legacy ticks fall on the ticks where the cumulative sum crosses a multiple of 0x10000.
- R9: With tick_i low, the running total holds and increment_i changes have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Fast tick, one clock per event |
| increment_i | input | 16 | Base cycles per fast tick; 0 means 0x10000 |
| legacy_tick_o | output | 1 | Slow tick pulse |
| ack_o | output | 1 | Local acknowledge pulse |

## Verification
The assertions take tick_i as a one-cycle qualifier. They check that increment_i need only be valid on cycles where tick_i is high; since it has no effect elsewhere, they place no limit on it between ticks. Back-to-back ticks on consecutive clocks are legal, and the pulse checks account for them. The stimulus drives tick_i and increment_i together, away from the sampling edge. It includes idle stretches in which increment_i is changed on purpose while tick_i stays low.

// File: rtl/frac_tick_bridge_pkg.sv
package frac_tick_bridge_pkg;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_ACK    = 2'd1,
    EV_LEGACY = 2'd2
  } tick_ev_e;

endpackage

// File: rtl/ftb_inc_norm.sv
module ftb_inc_norm #(
  parameter int unsigned PERIOD_LOG2 = 16,
  localparam int unsigned ACC_W = PERIOD_LOG2 + 1
) (
  input  logic [PERIOD_LOG2-1:0] inc_i,
  output logic [ACC_W-1:0]       inc_eff_o
);

  localparam logic [ACC_W-1:0] PERIOD = ACC_W'(1) << PERIOD_LOG2;

  // zero stands for a full period
  always_comb begin
    if (inc_i == '0) inc_eff_o = PERIOD;
    else             inc_eff_o = {1'b0, inc_i};
  end

endmodule

// File: rtl/ftb_accum.sv
module ftb_accum #(
  parameter int unsigned PERIOD_LOG2 = 16,
  localparam int unsigned ACC_W = PERIOD_LOG2 + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [ACC_W-1:0] inc_eff_i,
  output logic             wrap_o
);

  localparam logic [ACC_W-1:0] PERIOD = ACC_W'(1) << PERIOD_LOG2;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  // acc_q < PERIOD and inc_eff_i <= PERIOD, so sum fits and one subtract suffices
  assign sum    = acc_q + inc_eff_i;
  assign wrap_o = (sum >= PERIOD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (tick_i) acc_q <= wrap_o ? (sum - PERIOD) : sum;
  end

  AST_ACC_BELOW_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < PERIOD); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(acc_q)); // R9

  AST_FULL_INC_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && inc_eff_i == PERIOD) |=> $stable(acc_q)); // R6

endmodule

// File: rtl/ftb_pulse_out.sv
module ftb_pulse_out
  import frac_tick_bridge_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic wrap_i,
  output logic legacy_tick_o,
  output logic ack_o
);

  tick_ev_e ev_d, ev_q;

  always_comb begin
    ev_d = EV_NONE;
    if (tick_i) ev_d = wrap_i ? EV_LEGACY : EV_ACK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_q <= EV_NONE;
    else         ev_q <= ev_d;
  end

  assign legacy_tick_o = (ev_q == EV_LEGACY);
  assign ack_o         = (ev_q == EV_ACK);

  AST_ONE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({legacy_tick_o, ack_o})); // R5

  AST_TICK_GIVES_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (legacy_tick_o || ack_o)); // R5

  AST_NO_TICK_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !(legacy_tick_o || ack_o)); // R5

endmodule

// File: rtl/frac_tick_bridge.sv
module frac_tick_bridge #(
  parameter int unsigned PERIOD_LOG2 = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic [PERIOD_LOG2-1:0] increment_i,
  output logic                   legacy_tick_o,
  output logic                   ack_o
);

  localparam int unsigned ACC_W = PERIOD_LOG2 + 1;

  logic [ACC_W-1:0] inc_eff;
  logic             wrap;

  ftb_inc_norm #(.PERIOD_LOG2(PERIOD_LOG2)) u_inc_norm (
    .inc_i     (increment_i),
    .inc_eff_o (inc_eff)
  );

  ftb_accum #(.PERIOD_LOG2(PERIOD_LOG2)) u_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .inc_eff_i (inc_eff),
    .wrap_o    (wrap)
  );

  ftb_pulse_out u_pulse_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .wrap_i        (wrap),
    .legacy_tick_o (legacy_tick_o),
    .ack_o         (ack_o)
  );

  AST_ZERO_INC_LEGACY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && increment_i == '0) |=> legacy_tick_o); // R6

endmodule

// File: tb/frac_tick_bridge_bench.sv
module frac_tick_bridge_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [15:0] increment_i = '0;
  logic        legacy_tick_o;
  logic        ack_o;

  int total = 0;
  int bad = 0;
  int macc = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  frac_tick_bridge u_frac_tick_bridge (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .increment_i   (increment_i),
    .legacy_tick_o (legacy_tick_o),
    .ack_o         (ack_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    tick_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    macc = 0;
  endtask

  // called at a negedge; drives a tick, checks the pulse at the next negedge
  task automatic send_tick(input logic [15:0] inc, input string req, output bit was_legacy);
    int s;
    bit exp_leg;
    tick_i = 1'b1;
    increment_i = inc;
    s = macc + ((inc == 16'd0) ? 65536 : int'(inc));
    exp_leg = (s >= 65536);
    if (exp_leg) s -= 65536;
    macc = s;
    @(negedge clk_i);
    tick_i = 1'b0;
    check(legacy_tick_o == exp_leg, req, int'(legacy_tick_o), int'(exp_leg));
    check(ack_o == !exp_leg, req, int'(ack_o), int'(!exp_leg));
    was_legacy = legacy_tick_o;
  endtask

  task automatic t_reset();
    do_reset();
    check(legacy_tick_o == 1'b0 && ack_o == 1'b0, "R1 outputs idle", int'({legacy_tick_o, ack_o}), 0);
  endtask

  task automatic t_half();
    bit l;
    do_reset();
    send_tick(16'h8000, "R1 R4 first half tick ack", l);
    send_tick(16'h8000, "R2 R3 second half tick legacy", l);
    send_tick(16'h8000, "R8 remainder zero ack", l);
    @(negedge clk_i);
    check(!legacy_tick_o && !ack_o, "R5 pulse one clock wide", int'({legacy_tick_o, ack_o}), 0);
  endtask

  task automatic t_rate();
    bit l;
    int n_leg = 0;
    do_reset();
    for (int i = 0; i < 100; i++) begin
      send_tick(16'd11931, "R8 per-tick placement", l);
      if (l) n_leg++;
    end
    check(n_leg == 18, "R7 legacy count 100 ticks", n_leg, 18);
  endtask

  task automatic t_max();
    bit l;
    do_reset();
    send_tick(16'hFFFF, "R4 max inc ack", l);
    send_tick(16'h0001, "R3 exact period legacy", l);
    send_tick(16'hFFFF, "R3 total back to zero", l);
    send_tick(16'hFFFF, "R3 max inc wraps", l);
  endtask

  task automatic t_zero();
    bit l;
    do_reset();
    send_tick(16'h4000, "R2 preload", l);
    for (int i = 0; i < 3; i++) send_tick(16'h0000, "R6 zero inc legacy", l);
    send_tick(16'hC000, "R6 total unchanged by zero inc", l);
  endtask

  task automatic t_idle();
    bit l;
    do_reset();
    send_tick(16'h9000, "R2 idle preload", l);
    for (int i = 0; i < 5; i++) begin
      increment_i = 16'h0000 + 16'(i * 16'h3333);
      @(negedge clk_i);
      check(!legacy_tick_o && !ack_o, "R9 R5 no pulse while idle", int'({legacy_tick_o, ack_o}), 0);
    end
    send_tick(16'h7000, "R9 total held while idle", l);
    send_tick(16'h7000, "R9 total held while idle", l);
  endtask

  task automatic t_mid_reset();
    bit l;
    do_reset();
    send_tick(16'hF000, "R4 before reset", l);
    do_reset();
    send_tick(16'h1000, "R1 total cleared by reset", l);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_half();
    t_rate();
    t_max();
    t_zero();
    t_idle();
    t_mid_reset();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule